// File: doc/BRIEF.md
# Pipelined Bus Cycle Controller

This block is the master side of a simple processor bus. It takes read and write requests from an internal requester and runs one bus cycle for each. For every cycle it drives an address strobe, the address, the byte enables, the direction and the write data. A cycle ends only when the external ready input is sampled high. A read hands the captured data back to the requester together with a one-clock completion pulse.

Each bus state lasts two clocks: a first phase and a second phase. Ready and next-address are sampled only at the clock edge that ends a state. A cycle that starts from an idle bus always uses non-pipelined timing: an address state, then a data state, then wait states as needed. The external next-address input can switch the following cycle to pipelined timing. If it is high at the end of a data or wait state, a further request is pending and ready is low, then the next cycle's address and definition go out while the current cycle is still waiting. On completion, that early cycle skips straight to its data state.

Top module: `pbus_cycle_ctrl`

## Requirements
- R1: A request is accepted into a single holding slot. `req_ready` is high exactly when the slot is empty. Cycles go onto the bus in acceptance order, and `bus_addr`, `bus_be` and `bus_write` (1 = write, 0 = read) carry the values given with the request.
- R2: A bus state lasts two clocks, counted from the end of reset. `bus_ready` and `bus_na` are sampled only at the edge that ends a state. Their values at the edge in the middle of a state have no effect.
- R3: When the bus is idle and a request is held in the slot, the next state is an address state with `bus_ads` high. It is followed by a data state. `bus_ready` high at the end of the address state is ignored.
- R4: When `bus_ready` is sampled low at the end of a data or wait state, another wait state follows. There is no limit on how many.
- R5: Suppose `bus_na` is high and `bus_ready` is low at the end of a data or wait state while a request is held. The next state then shows that request's address and definition with `bus_ads` high, while the current cycle keeps waiting.
- R6: `bus_ads` stays high for both clocks of exactly one bus state per cycle.
- R7: When a cycle ends, `done` is high for one clock, starting at the clock after the ending edge. `done_write` gives the direction. For a read, `done_rdata` equals the `bus_rdata` present at that edge.
- R8: For a write, `bus_wdata_oe` is high with the request's data from the cycle's second state until the cycle ends. The same data stays driven through the first clock of the following state.
- R9: When a cycle ends, the next state depends on what is waiting. If the next cycle was already issued early, the next state is that cycle's data state. If a request is held but not yet issued, the next state is an address state with no idle gap. Otherwise the bus goes idle.
- R10: While reset is low, `bus_ads`, `done` and `bus_wdata_oe` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Holding slot empty |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_be | input | DATA_W/8 | Request byte enables |
| req_wdata | input | DATA_W | Request write data |
| done | output | 1 | Cycle completion pulse |
| done_write | output | 1 | Direction of the completed cycle |
| done_rdata | output | DATA_W | Data captured for a completed read |
| bus_ads | output | 1 | Address strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_be | output | DATA_W/8 | Bus byte enables |
| bus_write | output | 1 | Bus cycle direction |
| bus_wdata | output | DATA_W | Write data |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | DATA_W | Read data from the device |
| bus_ready | input | 1 | Cycle acknowledge |
| bus_na | input | 1 | Request for pipelined timing of the next cycle |

## Verification
Two events can fall on the same bus state: completion of the current cycle and the early issue of the next address. This happens when ready arrives in the very state where the early address is shown. The following state then holds both the hold phase of the finished write's data and the data of the promoted cycle. The bench provokes this with a high next-address probability, a moderate ready probability and back-to-back mixed requests. A reference model of the protocol predicts, state by state, when a strobe, an address, a completion and a data value must appear, and a scoreboard compares each issued cycle with the queued request.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T1P  = 3'd3,
    S_T2P  = 3'd4
  } bstate_e;

  // states in which the current cycle may be acknowledged
  function automatic logic in_data_state(bstate_e s);
    return (s == S_T2) || (s == S_T1P) || (s == S_T2P);
  endfunction

  // states in which the bus shows the early-issued next cycle
  function automatic logic shows_next(bstate_e s);
    return (s == S_T1P) || (s == S_T2P);
  endfunction

  // states that carry the address strobe
  function automatic logic strobe_state(bstate_e s);
    return (s == S_T1) || (s == S_T1P);
  endfunction

endpackage

// File: rtl/pcc_req_slot.sv
`timescale 1ns/1ps
module pcc_req_slot #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BE_W-1:0]   in_be,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              take,
  output logic              slot_v,
  output logic              slot_write,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [BE_W-1:0]   slot_be,
  output logic [DATA_W-1:0] slot_wdata
);

  logic accept;

  assign in_ready = !slot_v;
  assign accept   = in_valid && !slot_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v     <= 1'b0;
      slot_write <= 1'b0;
      slot_addr  <= '0;
      slot_be    <= '0;
      slot_wdata <= '0;
    end else if (accept) begin
      slot_v     <= 1'b1;
      slot_write <= in_write;
      slot_addr  <= in_addr;
      slot_be    <= in_be;
      slot_wdata <= in_wdata;
    end else if (take) begin
      slot_v     <= 1'b0;
    end
  end

  assert_take_needs_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> slot_v);

  assert_slot_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_v && !take) |=> (slot_v && $stable(slot_addr) && $stable(slot_write)));

endmodule

// File: rtl/pcc_bus_seq.sv
`timescale 1ns/1ps
module pcc_bus_seq
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_v,
  input  logic              slot_write,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic [BE_W-1:0]   slot_be,
  input  logic [DATA_W-1:0] slot_wdata,
  output logic              take,
  input  logic              bus_ready,
  input  logic              bus_na,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ads,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_be,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_oe,
  output logic              done,
  output logic              done_write,
  output logic [DATA_W-1:0] done_rdata
);

  bstate_e state, state_nx;
  logic              ph;
  logic              cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [BE_W-1:0]   cur_be;
  logic [DATA_W-1:0] cur_wdata;
  logic              hold_v;
  logic [DATA_W-1:0] hold_data;

  // named events
  logic st_end;    // this edge ends a bus state
  logic ack;       // current cycle acknowledged at this edge
  logic go_pipe;   // early issue of the held request
  logic launch;    // held request starts a non-pipelined cycle
  logic promote;   // early-issued request becomes current
  logic nx_shown;  // bus shows the early-issued cycle

  assign st_end   = ph;
  assign ack      = st_end && bus_ready && in_data_state(state);
  assign go_pipe  = st_end && (state == S_T2) && !bus_ready && bus_na && slot_v;
  assign launch   = st_end && slot_v && ((state == S_IDLE) || (ack && state == S_T2));
  assign promote  = ack && shows_next(state);
  assign take     = launch || promote;
  assign nx_shown = shows_next(state);

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE: if (st_end && slot_v) state_nx = S_T1;
      S_T1:   if (st_end) state_nx = S_T2;
      S_T2: begin
        if (ack)          state_nx = slot_v ? S_T1 : S_IDLE;
        else if (go_pipe) state_nx = S_T1P;
      end
      S_T1P: begin
        if (ack)         state_nx = S_T2;
        else if (st_end) state_nx = S_T2P;
      end
      S_T2P: if (ack) state_nx = S_T2;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= 1'b0;
      state <= S_IDLE;
    end else begin
      ph    <= !ph;
      state <= state_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_be    <= '0;
      cur_wdata <= '0;
    end else if (take) begin
      cur_write <= slot_write;
      cur_addr  <= slot_addr;
      cur_be    <= slot_be;
      cur_wdata <= slot_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v     <= 1'b0;
      hold_data  <= '0;
      done       <= 1'b0;
      done_write <= 1'b0;
      done_rdata <= '0;
    end else begin
      hold_v <= ack && cur_write;
      done   <= ack;
      if (ack) begin
        hold_data  <= cur_wdata;
        done_write <= cur_write;
        done_rdata <= bus_rdata;
      end
    end
  end

  assign bus_ads      = strobe_state(state);
  assign bus_addr     = nx_shown ? slot_addr  : cur_addr;
  assign bus_be       = nx_shown ? slot_be    : cur_be;
  assign bus_write    = nx_shown ? slot_write : cur_write;
  assign bus_wdata_oe = hold_v || (cur_write && in_data_state(state));
  assign bus_wdata    = hold_v ? hold_data : cur_wdata;

  assert_ads_whole_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ads && !ph) |=> bus_ads);

  assert_done_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_ready) && $past(ph)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cur_write) |=> (bus_wdata_oe && bus_wdata == $past(cur_wdata)));

  assert_early_needs_na_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nx_shown && !$past(nx_shown)) |-> ($past(bus_na) && !$past(bus_ready)));

  assert_idle_nonpipe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |=> (state == S_IDLE || state == S_T1));

endmodule

// File: rtl/pbus_cycle_ctrl.sv
`timescale 1ns/1ps
module pbus_cycle_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W/8-1:0]   req_be,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  done,
  output logic                  done_write,
  output logic [DATA_W-1:0]     done_rdata,
  output logic                  bus_ads,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [DATA_W/8-1:0]   bus_be,
  output logic                  bus_write,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_wdata_oe,
  input  logic [DATA_W-1:0]     bus_rdata,
  input  logic                  bus_ready,
  input  logic                  bus_na
);

  localparam int BE_W = DATA_W / 8;

  logic              slot_v;
  logic              slot_write;
  logic [ADDR_W-1:0] slot_addr;
  logic [BE_W-1:0]   slot_be;
  logic [DATA_W-1:0] slot_wdata;
  logic              take;

  pcc_req_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (req_valid),
    .in_ready   (req_ready),
    .in_write   (req_write),
    .in_addr    (req_addr),
    .in_be      (req_be),
    .in_wdata   (req_wdata),
    .take       (take),
    .slot_v     (slot_v),
    .slot_write (slot_write),
    .slot_addr  (slot_addr),
    .slot_be    (slot_be),
    .slot_wdata (slot_wdata)
  );

  pcc_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_v       (slot_v),
    .slot_write   (slot_write),
    .slot_addr    (slot_addr),
    .slot_be      (slot_be),
    .slot_wdata   (slot_wdata),
    .take         (take),
    .bus_ready    (bus_ready),
    .bus_na       (bus_na),
    .bus_rdata    (bus_rdata),
    .bus_ads      (bus_ads),
    .bus_addr     (bus_addr),
    .bus_be       (bus_be),
    .bus_write    (bus_write),
    .bus_wdata    (bus_wdata),
    .bus_wdata_oe (bus_wdata_oe),
    .done         (done),
    .done_write   (done_write),
    .done_rdata   (done_rdata)
  );

endmodule

// File: tb/tb_pbus_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_pbus_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        done, done_write;
  logic [31:0] done_rdata;
  logic        bus_ads;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic        bus_wdata_oe;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic        bus_na = 1'b0;

  always #2.5 clk = ~clk;

  pbus_cycle_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .done(done), .done_write(done_write), .done_rdata(done_rdata),
    .bus_ads(bus_ads), .bus_addr(bus_addr), .bus_be(bus_be), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_na(bus_na)
  );

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [3:0]  be;
    logic [31:0] d;
  } item_t;

  item_t exp_q[$];
  item_t out_c[2];
  int    out_st[2];
  int    n_out = 0;

  int total = 0;
  int bad = 0;
  bit run = 0;
  bit bph = 0;
  int pend = 0;
  bit acc_prev = 0;
  bit exp_ads = 0;
  bit exp_done = 0;
  bit exp_dw = 0;
  logic [31:0] exp_rd = '0;
  bit hold_exp = 0;
  logic [31:0] hold_d = '0;
  bit ads_ph0 = 0;
  int pr_ready = 50;
  int pr_na = 0;
  int n_pipe = 0;
  int cur_wait = 0;
  int max_wait = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, ex);
    end
  endtask

  // driver: pushes the expected bus cycle into the scoreboard queue
  task automatic send(input bit w, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] d);
    item_t it;
    @(posedge clk); #1;
    while (!req_ready) begin
      @(posedge clk); #1;
    end
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    it.w = w; it.a = a; it.be = be; it.d = d;
    exp_q.push_back(it);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(posedge clk);
    while (exp_q.size() != 0 || n_out != 0 || pend != 0) @(posedge clk);
    repeat (6) @(posedge clk);
  endtask

  task automatic send_rand(input int n);
    for (int i = 0; i < n; i++)
      send($urandom_range(0, 1), $urandom, 4'($urandom_range(1, 15)), $urandom);
  endtask

  // monitor and bus responder with protocol reference model
  initial begin
    item_t it;
    bit ending, rdy, na, oe_exp;
    forever begin
      @(negedge clk);
      if (run) begin
        pend += int'(acc_prev);
        acc_prev = req_valid && req_ready;
        // R7: completion pulse and captured data
        chk(done == exp_done, "R7", "done", 64'(done), 64'(exp_done));
        if (exp_done && done) begin
          chk(done_write == exp_dw, "R7", "done_write", 64'(done_write), 64'(exp_dw));
          if (!exp_dw) chk(done_rdata == exp_rd, "R7", "done_rdata", 64'(done_rdata), 64'(exp_rd));
        end
        exp_done = 0;
        if (!bph) begin
          for (int i = 0; i < n_out; i++) out_st[i]++;
          // R3 R5 R9: strobe appears exactly where the protocol model places a new cycle
          chk(bus_ads == exp_ads, "R9", "ads at state start", 64'(bus_ads), 64'(exp_ads));
          if (exp_ads) begin
            if (exp_q.size() == 0) begin
              chk(0, "R1", "cycle with no queued request", 0, 1);
            end else begin
              it = exp_q.pop_front();
              out_c[n_out] = it;
              out_st[n_out] = 1;
              n_out++;
              pend--;
              if (n_out == 2) n_pipe++;
            end
          end
          ads_ph0 = bus_ads;
        end else begin
          chk(bus_ads == ads_ph0, "R6", "ads second clock", 64'(bus_ads), 64'(ads_ph0));
        end
        // R1: address and definition of the newest issued cycle
        if (n_out > 0) begin
          it = out_c[n_out-1];
          chk(bus_addr == it.a, "R1", "bus_addr", 64'(bus_addr), 64'(it.a));
          chk(bus_write == it.w, "R1", "bus_write", 64'(bus_write), 64'(it.w));
          chk(bus_be == it.be, "R1", "bus_be", 64'(bus_be), 64'(it.be));
        end
        // R8: write data drive and hold
        if (!bph && hold_exp) begin
          chk(bus_wdata_oe == 1'b1, "R8", "hold oe", 64'(bus_wdata_oe), 1);
          chk(bus_wdata == hold_d, "R8", "hold data", 64'(bus_wdata), 64'(hold_d));
        end else begin
          oe_exp = (n_out > 0) && out_c[0].w && (out_st[0] >= 2);
          chk(bus_wdata_oe == oe_exp, "R8", "wdata_oe", 64'(bus_wdata_oe), 64'(oe_exp));
          if (oe_exp) chk(bus_wdata == out_c[0].d, "R8", "wdata", 64'(bus_wdata), 64'(out_c[0].d));
        end
        if (!bph) hold_exp = 0;
        // drive inputs for the coming edge
        bus_rdata = $urandom;
        rdy = ($urandom_range(0, 99) < pr_ready);
        na  = ($urandom_range(0, 99) < pr_na);
        if (!bph) begin
          // R2: mid-state values are random and must have no effect
          bus_ready = $urandom_range(0, 1) != 0;
          bus_na    = $urandom_range(0, 1) != 0;
        end else begin
          bus_ready = rdy;
          bus_na    = na;
          ending = (n_out > 0) && (out_st[0] >= 2) && rdy;
          if (n_out == 0)  exp_ads = (pend > 0);
          else if (ending) exp_ads = (n_out == 1) && (pend > 0);
          else exp_ads = (n_out == 1) && (out_st[0] >= 2) && na && (pend > 0);
          if (n_out > 0 && out_st[0] >= 2 && !rdy) begin
            cur_wait++;
            if (cur_wait > max_wait) max_wait = cur_wait;
          end
          if (ending) begin
            cur_wait = 0;
            exp_done = 1;
            exp_dw = out_c[0].w;
            exp_rd = bus_rdata;
            if (out_c[0].w) begin
              hold_exp = 1;
              hold_d = out_c[0].d;
            end
            out_c[0] = out_c[1];
            out_st[0] = out_st[1];
            n_out--;
          end
        end
        bph = !bph;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R4", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(req_ready == 1'b1, "R10", "req_ready", 64'(req_ready), 1);
    chk(bus_ads == 1'b0, "R10", "bus_ads", 64'(bus_ads), 0);
    chk(done == 1'b0, "R10", "done", 64'(done), 0);
    chk(bus_wdata_oe == 1'b0, "R10", "wdata_oe", 64'(bus_wdata_oe), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run = 1;

    // R3: single read then single write from an idle bus, ready always high
    pr_ready = 100; pr_na = 100;
    send(0, 32'h0000_1000, 4'hf, 32'h0);
    wait_idle();
    send(1, 32'h0000_2004, 4'h3, 32'hcafe_0001);
    wait_idle();

    // R5 R9: back-to-back with frequent pipelining
    pr_ready = 40; pr_na = 90;
    send_rand(30);
    wait_idle();

    // R4: long wait-state chains
    pr_ready = 4; pr_na = 50;
    send_rand(8);
    wait_idle();

    // R9: no pipelining, back-to-back non-pipelined cycles
    pr_ready = 60; pr_na = 0;
    send_rand(15);
    wait_idle();

    // R3: isolated requests with next-address always high
    pr_ready = 50; pr_na = 100;
    for (int i = 0; i < 6; i++) begin
      send_rand(1);
      wait_idle();
    end

    // R8: writes only, pipelined, to stress the hold phase
    pr_ready = 70; pr_na = 80;
    for (int i = 0; i < 12; i++) send(1, $urandom, 4'hf, $urandom);
    wait_idle();

    chk(n_pipe > 0, "R5", "pipelined cycles seen", 64'(n_pipe), 1);
    chk(max_wait >= 5, "R4", "longest wait chain", 64'(max_wait), 5);
    chk(exp_q.size() == 0, "R1", "unissued requests", 64'(exp_q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule